// File: doc/BRIEF.md
# Two-Way Cache Maintenance Engine

This block carries out maintenance work on the tag and line-state arrays of a small two-way set-associative cache. Every line has a valid flag and a modified flag. A requester hands over one command at a time on a valid/ready handshake. The command names an operation and a scope. The operation is invalidate, push, clear, or a cache on/off request. The scope is the whole cache, a single address, or a start address with a byte length. When a line that holds modified data has to reach memory, the engine raises a write-back request with the line address. It holds that request until memory answers with a one-cycle done pulse.

The arrays sit inside the block. A small install port loads a line into a chosen way, and a probe port reports whether an address is present and whether it is modified. These two ports stand in for the normal access path, which is not part of this block. Address commands look in both ways of the indexed set. A ranged command whose length is at least half the total cache capacity is widened to a full sweep.

Top module: `cmaint_engine`

## Requirements
- R1: After reset, busy and done are low, cmd_ready is high, cache_en and wbuf_en are low, and no address probes as present.
- R2: Invalidate (cmd_op 0) clears the valid and modified flags of each targeted line and never raises a write-back, even for a modified line.
- R3: Push (cmd_op 1) writes back a line only if it is valid and modified, then clears its modified flag and keeps it valid; clean or invalid lines are left untouched.
- R4: Clear (cmd_op 2) writes back a line that is valid and modified, then clears both flags; a clean valid line loses its valid flag without a write-back.
- R5: A single-address command (cmd_scope 1) ignores the low four address bits, searches way 0 and way 1 of the indexed set for a valid matching tag, and changes nothing when neither way matches.
- R6: A ranged command (cmd_scope 2) shorter than the threshold acts on every 16-byte line from the aligned start up to and including the line that holds start+length-1; a length of zero covers the start line only.
- R7: A ranged command whose byte length is at least WAY_BYTES (half the two-way capacity) performs the whole-cache version of its operation; one byte less walks line by line.
- R8: A whole-cache pass (cmd_scope 0 or 3) visits sets in ascending order with way 0 before way 1. Only one write-back is outstanding at a time, and wb_req and wb_addr hold until wb_done.
- R9: A cache on/off command (cmd_op 3, any scope) invalidates the whole cache and then sets cache_en and wbuf_en together to cmd_en_val in the cycle done rises; no other command changes them.
- R10: busy is high from the accepting clock edge until the last line is handled. done is then high for one cycle as busy falls. cmd_ready equals not busy. A pass with no write-backs takes exactly one cycle per visited entry.
- R11: An install (fill_en) writes a valid line with the given modified flag into the chosen way of the set indexed by fill_addr; an install while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle if offered |
| cmd_op | input | 2 | 0 invalidate, 1 push, 2 clear, 3 cache on/off |
| cmd_scope | input | 2 | 0 whole, 1 one address, 2 address plus length, 3 whole |
| cmd_addr | input | ADDR_W | Byte address of the command |
| cmd_len | input | ADDR_W | Byte length of a ranged command |
| cmd_en_val | input | 1 | New enable value for an on/off command |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| cache_en | output | 1 | Cache enable state |
| wbuf_en | output | 1 | Write-buffer enable state |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | ADDR_W | Line address to write back |
| wb_done | input | 1 | Write-back finished |
| fill_en | input | 1 | Install a line |
| fill_way | input | 1 | Way to install into |
| fill_addr | input | ADDR_W | Address of the installed line |
| fill_mod | input | 1 | Modified flag of the installed line |
| probe_addr | input | ADDR_W | Address to look up |
| probe_hit | output | 1 | Address present in either way |
| probe_way | output | 1 | Way that holds it |
| probe_mod | output | 1 | Present line is modified |

## Verification
The bench builds the engine with ADDR_W 32, 16-byte lines and WAY_BYTES of 256, so each way has 16 sets and a full sweep visits 32 entries. At this size a sweep can be counted cycle by cycle, and the widening threshold lies at 256 bytes, so lengths of 255 and 256 probe both sides of it. With 24-bit tags, aliased addresses that share a set but not a tag are easy to build. That makes the both-way search and the miss case simple to exercise.

// File: rtl/cmaint_pkg.sv
package cmaint_pkg;

    typedef enum logic [1:0] {
        OP_INVAL = 2'd0,
        OP_PUSH  = 2'd1,
        OP_CLEAR = 2'd2,
        OP_SETEN = 2'd3
    } maint_op_e;

    typedef enum logic [1:0] {
        SC_ALL   = 2'd0,
        SC_LINE  = 2'd1,
        SC_RANGE = 2'd2,
        SC_RSVD  = 2'd3
    } maint_scope_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_STEP = 2'd1,
        SQ_WB   = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic vld;
        logic mod;
    } line_st_t;

    // Data must leave the cache only for live modified lines under push/clear
    function automatic logic needs_wb(maint_op_e op, line_st_t cur);
        return cur.vld && cur.mod && (op != OP_INVAL);
    endfunction

    function automatic line_st_t next_line_st(maint_op_e op, line_st_t cur);
        line_st_t nxt;
        nxt = cur;
        if (op == OP_PUSH) begin
            if (cur.vld) nxt.mod = 1'b0;
        end else begin
            nxt = '{vld: 1'b0, mod: 1'b0};
        end
        return nxt;
    endfunction

endpackage

// File: rtl/cmaint_tag_store.sv
module cmaint_tag_store
    import cmaint_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 4,
    parameter int SET_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fill_en,
    input  logic                     fill_way,
    input  logic [ADDR_W-1:0]        fill_addr,
    input  logic                     fill_mod,
    input  logic                     upd_en,
    input  line_st_t                 upd_st,
    input  logic                     lk_whole,
    input  logic [SET_W:0]           lk_idx,
    input  logic [ADDR_W-LINE_W-1:0] lk_line,
    output logic                     lk_hit,
    output line_st_t                 lk_st,
    output logic [ADDR_W-1:0]        lk_addr,
    input  logic [ADDR_W-1:0]        probe_addr,
    output logic                     probe_hit,
    output logic                     probe_way,
    output logic                     probe_mod
);
    localparam int ENT_W  = SET_W + 1;
    localparam int NENT   = 2 ** ENT_W;
    localparam int TAG_W  = ADDR_W - SET_W - LINE_W;
    localparam int LNUM_W = ADDR_W - LINE_W;

    line_st_t         st_q  [NENT];
    logic [TAG_W-1:0] tag_q [NENT];

    logic [ENT_W-1:0] fill_ent;
    logic [ENT_W-1:0] lk_ent;
    assign fill_ent = {fill_addr[LINE_W+SET_W-1:LINE_W], fill_way};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < NENT; e++) st_q[e] <= '0;
        end else if (fill_en) begin
            st_q[fill_ent] <= '{vld: 1'b1, mod: fill_mod};
        end else if (upd_en) begin
            st_q[lk_ent] <= upd_st;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_ent] <= fill_addr[ADDR_W-1:LINE_W+SET_W];
    end

    // Both-way tag search, one copy for the engine and one for the probe
    logic [SET_W-1:0] eng_set, prb_set;
    logic [TAG_W-1:0] eng_tag, prb_tag;
    logic [1:0]       eng_way_hit, prb_way_hit;

    assign eng_set = lk_line[SET_W-1:0];
    assign eng_tag = lk_line[LNUM_W-1:SET_W];
    assign prb_set = probe_addr[LINE_W+SET_W-1:LINE_W];
    assign prb_tag = probe_addr[ADDR_W-1:LINE_W+SET_W];

    for (genvar w = 0; w < 2; w++) begin : g_way
        assign eng_way_hit[w] = st_q[{eng_set, 1'(w)}].vld
                             && (tag_q[{eng_set, 1'(w)}] == eng_tag);
        assign prb_way_hit[w] = st_q[{prb_set, 1'(w)}].vld
                             && (tag_q[{prb_set, 1'(w)}] == prb_tag);
    end

    always_comb begin
        if (lk_whole) begin
            lk_ent = lk_idx;
            lk_hit = 1'b1;
        end else begin
            lk_ent = {eng_set, ~eng_way_hit[0]};
            lk_hit = |eng_way_hit;
        end
    end

    assign lk_st   = st_q[lk_ent];
    assign lk_addr = {tag_q[lk_ent], lk_ent[ENT_W-1:1], {LINE_W{1'b0}}};

    assign probe_hit = |prb_way_hit;
    assign probe_way = ~prb_way_hit[0];
    assign probe_mod = probe_hit && st_q[{prb_set, probe_way}].mod;

    logic unused_probe;
    assign unused_probe = ^{probe_addr[LINE_W-1:0], fill_addr[LINE_W-1:0]};

endmodule

// File: rtl/cmaint_seq.sv
module cmaint_seq
    import cmaint_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LINE_W    = 4,
    parameter int SET_W     = 8,
    parameter int WAY_BYTES = 4096
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid,
    input  maint_op_e                cmd_op,
    input  maint_scope_e             cmd_scope,
    input  logic [ADDR_W-1:0]        cmd_addr,
    input  logic [ADDR_W-1:0]        cmd_len,
    input  logic                     cmd_en_val,
    input  logic                     lk_hit,
    input  line_st_t                 lk_st,
    input  logic                     wb_done,
    output logic                     cmd_ready,
    output logic                     busy,
    output logic                     done,
    output logic                     lk_whole,
    output logic [SET_W:0]           lk_idx,
    output logic [ADDR_W-LINE_W-1:0] lk_line,
    output logic                     upd_en,
    output line_st_t                 upd_st,
    output logic                     wb_req,
    output logic                     cache_en,
    output logic                     wbuf_en
);
    localparam int ENT_W  = SET_W + 1;
    localparam int LNUM_W = ADDR_W - LINE_W;
    localparam logic [ADDR_W-1:0] HALF_LEN = ADDR_W'(WAY_BYTES);

    seq_st_e           st_q;
    maint_op_e         op_q;
    logic              whole_q, seten_q, enval_q;
    logic [ENT_W-1:0]  idx_q;
    logic [LNUM_W-1:0] cur_q, end_q;

    logic [ADDR_W-1:0] last_byte;
    logic              go_whole, need_wb, step_fin, at_last;

    assign last_byte = cmd_addr + ((cmd_len == '0) ? '0 : (cmd_len - 1'b1));
    assign go_whole  = (cmd_op == OP_SETEN) || (cmd_scope == SC_ALL)
                    || (cmd_scope == SC_RSVD)
                    || ((cmd_scope == SC_RANGE) && (cmd_len >= HALF_LEN));

    assign busy      = (st_q != SQ_IDLE);
    assign cmd_ready = ~busy;
    assign lk_whole  = whole_q;
    assign lk_idx    = idx_q;
    assign lk_line   = cur_q;
    assign wb_req    = (st_q == SQ_WB);

    assign need_wb  = lk_hit && needs_wb(op_q, lk_st);
    assign step_fin = ((st_q == SQ_STEP) && !need_wb) || ((st_q == SQ_WB) && wb_done);
    assign at_last  = whole_q ? (idx_q == '1) : (cur_q == end_q);
    assign upd_en   = step_fin && lk_hit;
    assign upd_st   = next_line_st(op_q, lk_st);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= SQ_IDLE;
            op_q     <= OP_INVAL;
            whole_q  <= 1'b0;
            seten_q  <= 1'b0;
            enval_q  <= 1'b0;
            idx_q    <= '0;
            cur_q    <= '0;
            end_q    <= '0;
            done     <= 1'b0;
            cache_en <= 1'b0;
            wbuf_en  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st_q)
                SQ_IDLE: if (cmd_valid) begin
                    op_q    <= (cmd_op == OP_SETEN) ? OP_INVAL : cmd_op;
                    seten_q <= (cmd_op == OP_SETEN);
                    enval_q <= cmd_en_val;
                    whole_q <= go_whole;
                    idx_q   <= '0;
                    cur_q   <= cmd_addr[ADDR_W-1:LINE_W];
                    end_q   <= (cmd_scope == SC_RANGE) ? last_byte[ADDR_W-1:LINE_W]
                                                       : cmd_addr[ADDR_W-1:LINE_W];
                    st_q    <= SQ_STEP;
                end
                SQ_STEP: if (need_wb) st_q <= SQ_WB;
                default: ;
            endcase
            if (step_fin) begin
                if (at_last) begin
                    st_q <= SQ_IDLE;
                    done <= 1'b1;
                    if (seten_q) begin
                        cache_en <= enval_q;
                        wbuf_en  <= enval_q;
                    end
                end else begin
                    st_q  <= SQ_STEP;
                    idx_q <= idx_q + 1'b1;
                    cur_q <= cur_q + 1'b1;
                end
            end
        end
    end

    logic unused_low;
    assign unused_low = ^last_byte[LINE_W-1:0];

endmodule

// File: rtl/cmaint_engine.sv
module cmaint_engine
    import cmaint_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int WAY_BYTES  = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [1:0]        cmd_scope,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [ADDR_W-1:0] cmd_len,
    input  logic              cmd_en_val,
    output logic              busy,
    output logic              done,
    output logic              cache_en,
    output logic              wbuf_en,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_done,
    input  logic              fill_en,
    input  logic              fill_way,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_mod,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    output logic              probe_way,
    output logic              probe_mod
);
    localparam int LINE_W = $clog2(LINE_BYTES);
    localparam int SETS   = WAY_BYTES / LINE_BYTES;
    localparam int SET_W  = $clog2(SETS);
    localparam int LNUM_W = ADDR_W - LINE_W;

    logic              lk_whole, lk_hit, upd_en;
    logic [SET_W:0]    lk_idx;
    logic [LNUM_W-1:0] lk_line;
    line_st_t          lk_st, upd_st;

    cmaint_seq #(
        .ADDR_W(ADDR_W), .LINE_W(LINE_W), .SET_W(SET_W), .WAY_BYTES(WAY_BYTES)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (maint_op_e'(cmd_op)),
        .cmd_scope (maint_scope_e'(cmd_scope)),
        .cmd_addr  (cmd_addr),
        .cmd_len   (cmd_len),
        .cmd_en_val(cmd_en_val),
        .lk_hit    (lk_hit),
        .lk_st     (lk_st),
        .wb_done   (wb_done),
        .cmd_ready (cmd_ready),
        .busy      (busy),
        .done      (done),
        .lk_whole  (lk_whole),
        .lk_idx    (lk_idx),
        .lk_line   (lk_line),
        .upd_en    (upd_en),
        .upd_st    (upd_st),
        .wb_req    (wb_req),
        .cache_en  (cache_en),
        .wbuf_en   (wbuf_en)
    );

    cmaint_tag_store #(
        .ADDR_W(ADDR_W), .LINE_W(LINE_W), .SET_W(SET_W)
    ) store_i (
        .clk       (clk),
        .rst       (rst),
        .fill_en   (fill_en && !busy),
        .fill_way  (fill_way),
        .fill_addr (fill_addr),
        .fill_mod  (fill_mod),
        .upd_en    (upd_en),
        .upd_st    (upd_st),
        .lk_whole  (lk_whole),
        .lk_idx    (lk_idx),
        .lk_line   (lk_line),
        .lk_hit    (lk_hit),
        .lk_st     (lk_st),
        .lk_addr   (wb_addr),
        .probe_addr(probe_addr),
        .probe_hit (probe_hit),
        .probe_way (probe_way),
        .probe_mod (probe_mod)
    );

endmodule

// File: rtl/cmaint_engine_chk.sv
module cmaint_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              cmd_ready,
    input logic              wb_req,
    input logic              wb_done,
    input logic [ADDR_W-1:0] wb_addr,
    input logic              cache_en,
    input logic              wbuf_en
);
    AST_WB_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> busy);                                               // R8
    AST_WB_HELD: assert property (@(posedge clk) disable iff (rst)
        (wb_req && !wb_done) |=> (wb_req && $stable(wb_addr)));        // R8
    AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));                               // R10
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cmd_ready);                                           // R10
    AST_EN_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        (cache_en != $past(cache_en)) |-> done);                        // R9
    AST_EN_PAIRED: assert property (@(posedge clk) disable iff (rst)
        cache_en == wbuf_en);                                           // R9
endmodule

bind cmaint_engine cmaint_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .cmd_ready(cmd_ready),
    .wb_req   (wb_req),
    .wb_done  (wb_done),
    .wb_addr  (wb_addr),
    .cache_en (cache_en),
    .wbuf_en  (wbuf_en)
);

// File: tb/cmaint_engine_tb_top.sv
module cmaint_engine_tb_top;
    localparam int AW   = 32;
    localparam int WAYB = 256;
    localparam int NS   = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0, cmd_en_val = 1'b0;
    logic [1:0] cmd_op = '0, cmd_scope = '0;
    logic [AW-1:0] cmd_addr = '0, cmd_len = '0;
    logic cmd_ready, busy, done, cache_en, wbuf_en, wb_req;
    logic [AW-1:0] wb_addr;
    logic wb_done = 1'b0;
    logic fill_en = 1'b0, fill_way = 1'b0, fill_mod = 1'b0;
    logic [AW-1:0] fill_addr = '0, probe_addr = '0;
    logic probe_hit, probe_way, probe_mod;

    always #2 clk = ~clk;

    cmaint_engine #(.ADDR_W(AW), .LINE_BYTES(16), .WAY_BYTES(WAYB)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_scope(cmd_scope), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .cmd_en_val(cmd_en_val), .busy(busy), .done(done), .cache_en(cache_en),
        .wbuf_en(wbuf_en), .wb_req(wb_req), .wb_addr(wb_addr), .wb_done(wb_done),
        .fill_en(fill_en), .fill_way(fill_way), .fill_addr(fill_addr), .fill_mod(fill_mod),
        .probe_addr(probe_addr), .probe_hit(probe_hit), .probe_way(probe_way),
        .probe_mod(probe_mod)
    );

    int nchk = 0, nerr = 0;
    bit finished = 0;

    // Behavioural reference state
    bit          mv [NS][2];
    bit          mm [NS][2];
    int unsigned mt [NS][2];
    bit          exp_en = 0;
    logic [AW-1:0] expq[$], gotq[$], known[$];
    int lat = 0;

    task automatic chk(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void m_apply(int op, int s, int w);
        if (mv[s][w] && mm[s][w] && op != 0) expq.push_back((mt[s][w] << 8) | (s << 4));
        if (op == 1) begin
            if (mv[s][w]) mm[s][w] = 0;
        end else begin
            mv[s][w] = 0; mm[s][w] = 0;
        end
    endfunction

    function automatic void m_line(int op, int unsigned a);
        int s = (a >> 4) % NS;
        int unsigned t = a >> 8;
        if (mv[s][0] && mt[s][0] == t) m_apply(op, s, 0);
        else if (mv[s][1] && mt[s][1] == t) m_apply(op, s, 1);
    endfunction

    function automatic void m_cmd(int op, int sc, int unsigned a, int unsigned len, bit en);
        if (op == 3 || sc == 0 || sc == 3 || (sc == 2 && len >= WAYB)) begin
            for (int s = 0; s < NS; s++)
                for (int w = 0; w < 2; w++) m_apply((op == 3) ? 0 : op, s, w);
            if (op == 3) exp_en = en;
        end else if (sc == 1) begin
            m_line(op, a & ~32'hF);
        end else begin
            int unsigned first = a >> 4;
            int unsigned last  = (a + ((len == 0) ? 0 : len - 1)) >> 4;
            for (int unsigned l = first; l <= last; l++) m_line(op, l << 4);
        end
    endfunction

    // Write-back memory: answers two cycles after the request is seen
    always @(negedge clk) begin
        if (rst) begin
            wb_done = 1'b0; lat = 0;
        end else if (wb_done) begin
            wb_done = 1'b0; lat = 0;
        end else if (wb_req) begin
            lat++;
            if (lat >= 2) begin
                wb_done = 1'b1;
                gotq.push_back(wb_addr);
            end
        end
    end

    // Per-clock handshake checks
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R10", "cmd_ready vs busy", cmd_ready, !busy);
            if (done) chk("R10", "busy at done", busy, 0);
        end
    end

    task automatic do_fill(input bit w, input logic [AW-1:0] a, input bit m, input bit model);
        @(negedge clk);
        fill_en = 1; fill_way = w; fill_addr = a; fill_mod = m;
        @(negedge clk);
        fill_en = 0;
        known.push_back(a);
        if (model) begin
            int s = (a >> 4) % NS;
            mv[s][w] = 1; mm[s][w] = m; mt[s][w] = a >> 8;
        end
    endtask

    task automatic start_cmd(input int op, input int sc, input logic [AW-1:0] a,
                             input logic [AW-1:0] len, input bit en);
        expq.delete(); gotq.delete();
        m_cmd(op, sc, a, len, en);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1; cmd_op = 2'(op); cmd_scope = 2'(sc);
        cmd_addr = a; cmd_len = len; cmd_en_val = en;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic check_state(input string req);
        chk(req, "write-back count", gotq.size(), expq.size());
        for (int i = 0; i < expq.size() && i < gotq.size(); i++)
            chk(req, "write-back address", gotq[i], expq[i]);
        foreach (known[k]) begin
            int s = (known[k] >> 4) % NS;
            int unsigned t = known[k] >> 8;
            int hw = (mv[s][0] && mt[s][0] == t) ? 0 : ((mv[s][1] && mt[s][1] == t) ? 1 : -1);
            probe_addr = known[k];
            #1;
            chk(req, "probe hit", probe_hit, hw >= 0);
            if (hw >= 0) begin
                chk(req, "probe way", probe_way, hw);
                chk(req, "probe modified", probe_mod, mm[s][hw]);
            end
        end
        chk(req, "cache_en", cache_en, exp_en);
        chk(req, "wbuf_en", wbuf_en, exp_en);
    endtask

    task automatic run_cmd(input string req, input int op, input int sc,
                           input logic [AW-1:0] a, input logic [AW-1:0] len, input bit en);
        int cyc;
        start_cmd(op, sc, a, len, en);
        wait_done(cyc);
        chk(req, "done reached", done, 1);
        check_state(req);
    endtask

    task automatic summary();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            nerr++;
            $display("FAIL R10 watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        int cyc;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "cmd_ready", cmd_ready, 1);
        chk("R1", "cache_en", cache_en, 0);
        chk("R1", "wbuf_en", wbuf_en, 0);
        probe_addr = 32'h1000; #1;
        chk("R1", "probe after reset", probe_hit, 0);

        // R11 installs
        do_fill(0, 32'h1000, 1, 1);
        do_fill(1, 32'h2000, 0, 1);
        do_fill(0, 32'h1230, 1, 1);
        do_fill(1, 32'h3230, 1, 1);
        do_fill(1, 32'h50F0, 1, 1);
        check_state("R11");

        run_cmd("R3 R5 unaligned push", 1, 1, 32'h1235, 0, 0);
        run_cmd("R3 clean push", 1, 1, 32'h1230, 0, 0);
        run_cmd("R5 way1 search", 1, 1, 32'h3230, 0, 0);
        run_cmd("R5 miss", 2, 1, 32'h7000, 0, 0);
        run_cmd("R4 modified clear", 2, 1, 32'h1000, 0, 0);
        run_cmd("R2 clean inval", 0, 1, 32'h2000, 0, 0);
        do_fill(1, 32'h2000, 1, 1);
        run_cmd("R2 modified inval", 0, 1, 32'h2008, 0, 0);

        // R6 ranges
        for (int i = 4; i < 8; i++) do_fill(0, 32'h4000 | (i << 4), 1, 1);
        run_cmd("R6 two lines", 1, 2, 32'h4048, 32'h10, 0);
        run_cmd("R6 zero length", 1, 2, 32'h4060, 0, 0);

        // R7 just below threshold walks lines of tag 0 only
        do_fill(0, 32'h0010, 1, 1);
        do_fill(1, 32'h1020, 1, 1);
        run_cmd("R7 below threshold", 1, 2, 32'h0, 255, 0);

        // R7 R8 threshold reached: whole clear in set/way order
        do_fill(0, 32'h8020, 1, 1);
        run_cmd("R7 R8 whole clear", 2, 2, 32'h9000, 256, 0);
        run_cmd("R8 scope three", 1, 3, 32'h0, 0, 0);

        // R10 timing: 32 entries, no write-backs
        start_cmd(0, 0, 0, 0, 0);
        wait_done(cyc);
        chk("R10", "cycles to done", cyc, 2 * NS);
        @(negedge clk);
        chk("R10", "done width", done, 0);
        check_state("R10");

        // R9 on/off
        do_fill(0, 32'h7700, 1, 1);
        run_cmd("R9 enable", 3, 0, 0, 0, 1);
        run_cmd("R9 disable", 3, 2, 32'h123, 4, 0);
        run_cmd("R9 push keeps enables", 1, 0, 0, 0, 1);

        // R11 install while busy is dropped
        start_cmd(0, 0, 0, 0, 0);
        @(negedge clk);
        fill_en = 1; fill_way = 0; fill_addr = 32'h6600; fill_mod = 1;
        @(negedge clk);
        fill_en = 0;
        known.push_back(32'h6600);
        wait_done(cyc);
        check_state("R11 busy fill");

        // R2 whole invalidate drops modified data
        do_fill(0, 32'h0330, 1, 1);
        do_fill(1, 32'h0E40, 1, 1);
        run_cmd("R2 whole inval", 0, 0, 0, 0, 0);

        // R4 clean line clear
        do_fill(0, 32'h0A00, 0, 1);
        run_cmd("R4 clean clear", 2, 1, 32'h0A00, 0, 0);

        repeat (3) @(negedge clk);
        summary();
    end

endmodule